// File: doc/BRIEF.md
# Extended Capability Chain Walker

This engine walks the chain of extended capability headers kept in a 4 KB configuration memory. It has one read port with one cycle of latency and one write port. It handles two kinds of command. A lookup returns the byte offset of the first header whose capability ID equals the requested one, or zero when no header matches. An append adds a new header to the chain. When the new header sits at the chain base it is simply written there. Otherwise the engine walks to the last header, rewrites that header's next field to point at the new offset, and then writes the new header.

Each header is a 32-bit word. Bits 15:0 hold the capability ID, bits 19:16 the version and bits 31:20 the byte offset of the next header, where zero ends the chain. A walk always begins at byte offset 0x100. The engine reports through a one-cycle `done` pulse, which carries a 12-bit result offset and an error flag. A visit counter stops a corrupted, circular chain, so such a chain ends in an error and the engine cannot hang.

Top module: `ecap_walker`

## Requirements
- R1: A header word holds the ID in bits 15:0, the version in bits 19:16 and the next offset in bits 31:20. Every walk reads byte offset 0x100 first.
- R2: A lookup returns the offset of the first header along the chain whose ID equals `req_id`, with `err` low. If the walk reaches a header whose next field is 0 without a match, the result is 0 with `err` low.
- R3: If the word at 0x100 is all zero, the chain is empty. A lookup then returns 0 with `err` low, whatever ID is requested, even ID 0.
- R4: A next offset that is below 0x100 or above 0xFF8 ends the command with `err` high and result 0.
- R5: An append at offset 0x100 performs exactly one write: `{12'h000, req_ver, req_id}` to 0x100. The result is 0x100.
- R6: An append at any other offset does not compare IDs. It walks to the header whose next field is 0 and rewrites that header with bits 31:20 set to the new offset and bits 19:0 kept. It then writes `{12'h000, req_ver, req_id}` at the new offset. The result is the new offset.
- R7: An append whose offset is not a multiple of 4 or lies outside 0x100..0xFF8 ends with `err` high and writes nothing. An append at an offset other than 0x100 into an empty chain also ends with `err` high and writes nothing.
- R8: A walk that would visit more than MAX_VISITS headers (default 1024) ends with `err` high and result 0.
- R9: If `find_req` and `app_req` are both high in an idle cycle, the lookup is carried out and the append is dropped. Requests that arrive while `busy` is high are ignored.
- R10: `done` is a one-cycle pulse, and `busy` is low while it is high. A read returns data on `rd_data` in the cycle after `rd_en`. The engine never reads and writes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| find_req | input | 1 | Start a lookup |
| app_req | input | 1 | Start an append |
| req_id | input | 16 | Capability ID to look up or to append |
| req_ver | input | 4 | Version for the appended header |
| app_off | input | 12 | Byte offset of the appended header |
| rd_en | output | 1 | Memory read strobe |
| rd_addr | output | 12 | Memory read byte address |
| rd_data | input | 32 | Read data, valid one cycle after rd_en |
| wr_en | output | 1 | Memory write strobe |
| wr_addr | output | 12 | Memory write byte address |
| wr_data | output | 32 | Memory write data |
| busy | output | 1 | Command in progress |
| done | output | 1 | Command finished (one-cycle pulse) |
| result | output | 12 | Found or appended offset, 0 on a miss or an error |
| err | output | 1 | Error flag, valid with done |

## Verification
A lookup and an append can be requested in the same idle cycle. The bench provokes this by raising both strobes on the same edge, with a valid chain in memory and an append offset that is free. It judges the outcome in two ways. First, the result must equal the lookup answer. Second, both the chain tail and the word at the append offset must be unchanged, which shows the append left no trace. A second form of collision, an append strobe raised in the middle of a running lookup, is judged the same way.

// File: rtl/ecap_walker.sv
module ecap_walker #(
  parameter int LIST_BASE  = 'h100,
  parameter int MAX_VISITS = 1024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        find_req,
  input  logic        app_req,
  input  logic [15:0] req_id,
  input  logic [3:0]  req_ver,
  input  logic [11:0] app_off,
  output logic        rd_en,
  output logic [11:0] rd_addr,
  input  logic [31:0] rd_data,
  output logic        wr_en,
  output logic [11:0] wr_addr,
  output logic [31:0] wr_data,
  output logic        busy,
  output logic        done,
  output logic [11:0] result,
  output logic        err
);
  localparam int AW = 12;
  localparam int CW = $clog2(MAX_VISITS + 1);
  localparam logic [AW-1:0] BASE  = AW'(LIST_BASE);
  localparam logic [AW-1:0] LIMIT = AW'((1 << AW) - 8);
  localparam logic [CW-1:0] LAST  = CW'(MAX_VISITS - 1);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_CHK, S_WTAIL, S_WNEW} st_t;

  st_t            st;
  logic [AW-1:0]  cur, off_q;
  logic [15:0]    id_q;
  logic [3:0]     ver_q;
  logic [19:0]    tail_lo;
  logic           is_app;
  logic [CW-1:0]  cnt;
  logic           done_q, err_q;
  logic [AW-1:0]  res_q;

  wire [AW-1:0] nxt     = rd_data[31:20];
  wire          bad_off = (app_off[1:0] != 2'b00) || (app_off < BASE) || (app_off > LIMIT);
  wire          bad_nxt = (nxt < BASE) || (nxt > LIMIT);

  assign busy    = (st != S_IDLE);
  assign done    = done_q;
  assign err     = err_q;
  assign result  = res_q;
  assign rd_en   = (st == S_RD);
  assign rd_addr = cur;
  assign wr_en   = (st == S_WTAIL) || (st == S_WNEW);
  assign wr_addr = (st == S_WTAIL) ? cur : off_q;
  assign wr_data = (st == S_WTAIL) ? {off_q, tail_lo} : {12'h000, ver_q, id_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cur     <= BASE;
      off_q   <= '0;
      id_q    <= '0;
      ver_q   <= '0;
      tail_lo <= '0;
      is_app  <= 1'b0;
      cnt     <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      res_q   <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st)
        S_IDLE: begin
          cur <= BASE;
          cnt <= '0;
          if (find_req) begin
            is_app <= 1'b0;
            id_q   <= req_id;
            st     <= S_RD;
          end else if (app_req) begin
            is_app <= 1'b1;
            id_q   <= req_id;
            ver_q  <= req_ver;
            off_q  <= app_off;
            if (bad_off) begin
              done_q <= 1'b1; err_q <= 1'b1; res_q <= '0;
            end else if (app_off == BASE) begin
              st <= S_WNEW;
            end else begin
              st <= S_RD;
            end
          end
        end
        S_RD: st <= S_CHK;
        S_CHK: begin
          if (cur == BASE && rd_data == 32'h0) begin
            st <= S_IDLE; done_q <= 1'b1; err_q <= is_app; res_q <= '0;
          end else if (!is_app && rd_data[15:0] == id_q) begin
            st <= S_IDLE; done_q <= 1'b1; err_q <= 1'b0; res_q <= cur;
          end else if (nxt == '0) begin
            if (is_app) begin
              tail_lo <= rd_data[19:0];
              st      <= S_WTAIL;
            end else begin
              st <= S_IDLE; done_q <= 1'b1; err_q <= 1'b0; res_q <= '0;
            end
          end else if (bad_nxt || cnt == LAST) begin
            st <= S_IDLE; done_q <= 1'b1; err_q <= 1'b1; res_q <= '0;
          end else begin
            cur <= nxt;
            cnt <= cnt + 1'b1;
            st  <= S_RD;
          end
        end
        S_WTAIL: st <= S_WNEW;
        S_WNEW: begin
          st <= S_IDLE; done_q <= 1'b1; err_q <= 1'b0; res_q <= off_q;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ecap_walker_chk.sv
module ecap_walker_chk #(
  parameter int LIST_BASE = 'h100
) (
  input logic        clk,
  input logic        rst_n,
  input logic        find_req,
  input logic        app_req,
  input logic        rd_en,
  input logic [11:0] rd_addr,
  input logic        wr_en,
  input logic [11:0] wr_addr,
  input logic        busy,
  input logic        done,
  input logic [11:0] result,
  input logic        err
);
  localparam logic [11:0] BASE  = 12'(LIST_BASE);
  localparam logic [11:0] LIMIT = 12'hFF8;

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r10_one_access: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && wr_en));
  a_r10_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (find_req || app_req)) |=> (busy || done));
  a_r4_rd_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (rd_addr >= BASE && rd_addr <= LIMIT));
  a_r4_err_zero_result: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (result == 12'h000));
  a_r7_wr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_addr[1:0] == 2'b00 && wr_addr >= BASE && wr_addr <= LIMIT));
endmodule

bind ecap_walker ecap_walker_chk #(.LIST_BASE(LIST_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .find_req(find_req), .app_req(app_req),
  .rd_en(rd_en), .rd_addr(rd_addr), .wr_en(wr_en), .wr_addr(wr_addr),
  .busy(busy), .done(done), .result(result), .err(err)
);

// File: tb/ecap_walker_bench.sv
`timescale 1ns/1ps
module ecap_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        find_req = 1'b0, app_req = 1'b0;
  logic [15:0] req_id = '0;
  logic [3:0]  req_ver = '0;
  logic [11:0] app_off = '0;
  logic        rd_en, wr_en, busy, done, err;
  logic [11:0] rd_addr, wr_addr, result;
  logic [31:0] rd_data, wr_data;
  logic [31:0] mem [1024];
  int checks = 0, fails = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  ecap_walker u_ecap_walker (
    .clk(clk), .rst_n(rst_n), .find_req(find_req), .app_req(app_req),
    .req_id(req_id), .req_ver(req_ver), .app_off(app_off),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .done(done), .result(result), .err(err)
  );

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr[11:2]];
    if (wr_en) mem[wr_addr[11:2]] <= wr_data;
  end

  function automatic logic [31:0] hdr(input logic [11:0] n, input logic [3:0] v, input logic [15:0] id);
    return {n, v, id};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
  endtask

  task automatic wait_done();
    while (done !== 1'b1) @(negedge clk);
  endtask

  task automatic do_find(input logic [15:0] id, input logic [11:0] exp_res, input logic exp_err, input string tag);
    @(negedge clk);
    find_req = 1'b1; req_id = id;
    @(negedge clk);
    find_req = 1'b0;
    wait_done();
    chk({tag, " result"}, {20'h0, result}, {20'h0, exp_res});
    chk({tag, " err"}, {31'h0, err}, {31'h0, exp_err});
  endtask

  task automatic do_app(input logic [11:0] off, input logic [15:0] id, input logic [3:0] ver,
                        input logic [11:0] exp_res, input logic exp_err, input string tag);
    @(negedge clk);
    app_req = 1'b1; app_off = off; req_id = id; req_ver = ver;
    @(negedge clk);
    app_req = 1'b0;
    wait_done();
    chk({tag, " result"}, {20'h0, result}, {20'h0, exp_res});
    chk({tag, " err"}, {31'h0, err}, {31'h0, exp_err});
  endtask

  task automatic build_list();
    clear_mem();
    mem['h100 >> 2] = hdr(12'h140, 4'h1, 16'h0003);
    mem['h140 >> 2] = hdr(12'h180, 4'h1, 16'h000E);
    mem['h180 >> 2] = hdr(12'h000, 4'h2, 16'h0001);
  endtask

  task automatic t_reset();
    chk("R10 reset busy", {31'h0, busy}, 32'h0);
    chk("R10 reset done", {31'h0, done}, 32'h0);
    chk("R10 reset rd_en", {31'h0, rd_en}, 32'h0);
    chk("R10 reset wr_en", {31'h0, wr_en}, 32'h0);
  endtask

  task automatic t_find();
    build_list();
    do_find(16'h0003, 12'h100, 1'b0, "R1 first header at base");
    do_find(16'h000E, 12'h140, 1'b0, "R2 middle match");
    do_find(16'h0001, 12'h180, 1'b0, "R2 tail match");
    do_find(16'h0010, 12'h000, 1'b0, "R2 miss");
    mem['h180 >> 2] = hdr(12'h000, 4'h2, 16'h000E);
    do_find(16'h000E, 12'h140, 1'b0, "R2 first of duplicates");
  endtask

  task automatic t_empty();
    clear_mem();
    do_find(16'h0005, 12'h000, 1'b0, "R3 empty list");
    do_find(16'h0000, 12'h000, 1'b0, "R3 empty list id zero");
    do_app(12'h140, 16'h0002, 4'h1, 12'h000, 1'b1, "R7 append into empty");
    chk("R7 empty append no write", mem['h140 >> 2], 32'h0);
  endtask

  task automatic t_append();
    clear_mem();
    do_app(12'h100, 16'h0001, 4'h1, 12'h100, 1'b0, "R5 append at base");
    chk("R5 base header", mem['h100 >> 2], 32'h0001_0001);
    do_app(12'h180, 16'h0018, 4'h1, 12'h180, 1'b0, "R6 append second");
    chk("R6 tail next patched", mem['h100 >> 2], 32'h1801_0001);
    chk("R6 new header", mem['h180 >> 2], 32'h0001_0018);
    do_app(12'h200, 16'h0001, 4'h3, 12'h200, 1'b0, "R6 append id equal to base");
    chk("R6 ids not compared", mem['h180 >> 2], 32'h2001_0018);
    chk("R6 third header", mem['h200 >> 2], 32'h0003_0001);
    chk("R6 base untouched", mem['h100 >> 2], 32'h1801_0001);
    do_find(16'h0018, 12'h180, 1'b0, "R6 find appended");
    do_app(12'h282, 16'h0009, 4'h1, 12'h000, 1'b1, "R7 misaligned");
    chk("R7 misaligned no tail write", mem['h200 >> 2], 32'h0003_0001);
    chk("R7 misaligned no new write", mem['h280 >> 2], 32'h0);
    do_app(12'h0F0, 16'h0009, 4'h1, 12'h000, 1'b1, "R7 below base");
    do_app(12'hFFC, 16'h0009, 4'h1, 12'h000, 1'b1, "R7 above limit");
    chk("R7 above limit no write", mem['hFFC >> 2], 32'h0);
    chk("R7 tail still intact", mem['h200 >> 2], 32'h0003_0001);
  endtask

  task automatic t_range();
    clear_mem();
    mem['h100 >> 2] = hdr(12'hFFC, 4'h1, 16'h0003);
    do_find(16'h0099, 12'h000, 1'b1, "R4 next above limit");
    mem['h100 >> 2] = hdr(12'h0C0, 4'h1, 16'h0003);
    do_find(16'h0099, 12'h000, 1'b1, "R4 next below base");
    mem['h100 >> 2] = hdr(12'hFF8, 4'h1, 16'h0003);
    mem['hFF8 >> 2] = hdr(12'h000, 4'h1, 16'h0042);
    do_find(16'h0042, 12'hFF8, 1'b0, "R4 next at limit is legal");
  endtask

  task automatic t_loop();
    clear_mem();
    mem['h100 >> 2] = hdr(12'h200, 4'h1, 16'h0003);
    mem['h200 >> 2] = hdr(12'h100, 4'h1, 16'h0004);
    do_find(16'h0077, 12'h000, 1'b1, "R8 circular chain");
    do_app(12'h300, 16'h0007, 4'h1, 12'h000, 1'b1, "R8 circular append");
    chk("R8 no write on circular append", mem['h300 >> 2], 32'h0);
  endtask

  task automatic t_collide();
    build_list();
    @(negedge clk);
    find_req = 1'b1; app_req = 1'b1; req_id = 16'h000E; req_ver = 4'h1; app_off = 12'h400;
    @(negedge clk);
    find_req = 1'b0; app_req = 1'b0;
    wait_done();
    chk("R9 simultaneous lookup wins", {20'h0, result}, 32'h140);
    chk("R9 simultaneous no append", mem['h400 >> 2], 32'h0);
    chk("R9 simultaneous tail kept", mem['h180 >> 2], hdr(12'h000, 4'h2, 16'h0001));
    @(negedge clk);
    find_req = 1'b1; req_id = 16'h0010;
    @(negedge clk);
    find_req = 1'b0;
    @(negedge clk);
    chk("R9 busy during walk", {31'h0, busy}, 32'h1);
    app_req = 1'b1; app_off = 12'h300; req_id = 16'h0055;
    @(negedge clk);
    app_req = 1'b0;
    wait_done();
    chk("R9 walk result unchanged", {20'h0, result}, 32'h0);
    repeat (8) @(negedge clk);
    chk("R9 busy append ignored", mem['h300 >> 2], 32'h0);
    chk("R9 tail not patched", mem['h180 >> 2], hdr(12'h000, 4'h2, 16'h0001));
    chk("R10 idle after done", {31'h0, busy}, 32'h0);
  endtask

  initial begin
    clear_mem();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_find();
    t_empty();
    t_append();
    t_range();
    t_loop();
    t_collide();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule